// File: doc/BRIEF.md
# Nested-Escape Instruction Decoder

This block turns one 16-bit instruction word of a small register machine into the control fields the execution stages need. The word is read as four nibbles. From the top down they are a destination register, source A, source B, and a primary opcode in the lowest nibble. When the primary opcode is all ones, the word escapes into a single-source format, and bits [7:4] then carry a secondary opcode. When that secondary opcode is also all ones, the word escapes again into a single-register format, and bits [11:8] carry a tertiary opcode. The decoder resolves these three tiers. It reports which tier matched, the opcode inside that tier, an ALU operation code, an 8-bit immediate and a set of class flags. Encodings that are reserved or duplicated are flagged as illegal.

The decode is registered. A word presented with `in_valid` high is decoded at the next rising clock edge. The result appears with `out_valid` one cycle later, so the block drops straight into a pipeline stage boundary. In register numbering, index 14 is the program counter and index 15 is the status register. The decoder passes the indices through and does not treat them specially.

Top module: `nest_decoder`

## Requirements
- R1: While `rst_n` is low and after it is released, until the first valid word: `out_valid` is 0, `fmt` is 0, `sub_op` is 0, `imm` is 0, `alu_op` is 15 (none), and every class flag is 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, every decoded output holds its previous value.
- R3: `rd`, `ra` and `rb` always carry instruction bits [15:12], [11:8] and [7:4] of the last accepted word, whatever the format.
- R4: If bits [3:0] are not 0xF, `fmt` is 0 and `sub_op` is bits [3:0]. Codes 0 and 1 are the low and high immediate loads: `imm` = {bits[11:8], bits[7:4]}, `alu_op` = 15, and no class flag is set.
- R5: Primary codes 2 and 3 set `is_load`, and codes 4 and 5 set `is_store`. `mem_wide` is set for codes 3 and 5 only.
- R6: Primary codes 6..13 give `alu_op` 0..7 in order: add, add-with-carry, and, or, xor, shift left, shift right logical, shift right arithmetic. Primary code 14 sets `is_branch` with `alu_op` 15.
- R7: If bits [3:0] are 0xF and bits [7:4] are not 0xF, `fmt` is 1 and `sub_op` is bits [7:4]. The ALU codes are: 0 gives 8 (pass), 1 gives 9 (negate), 2 gives 10 (invert), 3 gives 11 (compare) and 5 gives 12 (byte swap). Code 4 sets `is_call` with `alu_op` 15.
- R8: In the single-source format, codes 6 and 8 set `is_io_rd`, and codes 7 and 9 set `is_io_wr`. Codes 8 and 9 also give `imm` = {4'h0, bits[11:8]}, while codes 6 and 7 give `imm` 0.
- R9: In the single-source format, codes 10, 11 and 12 give `alu_op` 0, 2 and 3 with `imm` = {4'h0, bits[11:8]}. Code 13 is a shift by immediate: `alu_op` is 6 if bit 11 is 1 and 5 otherwise, and `imm` = {5'h0, bits[10:8]}. Code 14 gives `alu_op` 7 with `imm` = {4'h0, bits[11:8]}.
- R10: If bits [7:0] are 0xFF, `fmt` is 2 and `sub_op` is bits [11:8]. Codes 0..10 set `is_excr` with `alu_op` 15 and `imm` 0.
- R11: Single-register codes 11..15 set `is_illegal`, clear all other class flags, and give `alu_op` 15 and `imm` 0.
- R12: At most one of `is_load`, `is_store`, `is_io_rd`, `is_io_wr`, `is_branch`, `is_call`, `is_excr` and `is_illegal` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| instr | input | 16 | Instruction word |
| out_valid | output | 1 | Decoded fields valid |
| fmt | output | 2 | Tier: 0 three-register, 1 single-source, 2 single-register |
| sub_op | output | 4 | Opcode within the matched tier |
| rd | output | 4 | Destination register index |
| ra | output | 4 | Source A register index |
| rb | output | 4 | Source B register index |
| alu_op | output | 4 | ALU operation code, 15 = none |
| imm | output | 8 | Immediate value |
| is_load | output | 1 | Memory read |
| is_store | output | 1 | Memory write |
| mem_wide | output | 1 | 16-bit memory access |
| is_io_rd | output | 1 | I/O port read |
| is_io_wr | output | 1 | I/O port write |
| is_branch | output | 1 | Conditional branch |
| is_call | output | 1 | Subroutine call |
| is_excr | output | 1 | Exception-state operation |
| is_illegal | output | 1 | Reserved or invalid encoding |

## Verification
The assertions assume that `instr` is a fully known value on every edge where `in_valid` is high, and that `rst_n` is low for at least one edge before the first word. The stimulus drives both inputs only at falling edges, which keeps every value stable across each rising edge. One case drops `in_valid` and changes `instr` at the same time, to show that the outputs hold their values. The word sequence covers every primary, secondary and tertiary code, including the all-ones word and escapes where the neighbouring fields are all ones.

// File: rtl/nest_decoder.sv
module nest_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] instr,
  output logic        out_valid,
  output logic [1:0]  fmt,
  output logic [3:0]  sub_op,
  output logic [3:0]  rd,
  output logic [3:0]  ra,
  output logic [3:0]  rb,
  output logic [3:0]  alu_op,
  output logic [7:0]  imm,
  output logic        is_load,
  output logic        is_store,
  output logic        mem_wide,
  output logic        is_io_rd,
  output logic        is_io_wr,
  output logic        is_branch,
  output logic        is_call,
  output logic        is_excr,
  output logic        is_illegal
);

  localparam logic [3:0] ALU_NONE = 4'hF;

  logic [3:0] n_d, n_a, n_b, n_o;
  assign {n_d, n_a, n_b, n_o} = instr;

  wire esc1 = (n_o == 4'hF);
  wire esc2 = esc1 && (n_b == 4'hF);

  logic [1:0] c_fmt;
  logic [3:0] c_sub, c_alu;
  logic [7:0] c_imm;
  logic [8:0] c_fl; // ld, st, wide, io_rd, io_wr, br, call, excr, illegal

  always_comb begin
    c_alu = ALU_NONE;
    c_imm = 8'h00;
    c_fl  = 9'h000;
    if (esc2) begin
      c_fmt = 2'd2;
      c_sub = n_a;
      if (n_a <= 4'hA) c_fl[1] = 1'b1;
      else             c_fl[0] = 1'b1;
    end else if (esc1) begin
      c_fmt = 2'd1;
      c_sub = n_b;
      case (n_b)
        4'h0: c_alu = 4'h8;
        4'h1: c_alu = 4'h9;
        4'h2: c_alu = 4'hA;
        4'h3: c_alu = 4'hB;
        4'h4: c_fl[2] = 1'b1;
        4'h5: c_alu = 4'hC;
        4'h6: c_fl[5] = 1'b1;
        4'h7: c_fl[4] = 1'b1;
        4'h8: begin c_fl[5] = 1'b1; c_imm = {4'h0, n_a}; end
        4'h9: begin c_fl[4] = 1'b1; c_imm = {4'h0, n_a}; end
        4'hA: begin c_alu = 4'h0; c_imm = {4'h0, n_a}; end
        4'hB: begin c_alu = 4'h2; c_imm = {4'h0, n_a}; end
        4'hC: begin c_alu = 4'h3; c_imm = {4'h0, n_a}; end
        4'hD: begin c_alu = n_a[3] ? 4'h6 : 4'h5; c_imm = {5'h00, n_a[2:0]}; end
        default: begin c_alu = 4'h7; c_imm = {4'h0, n_a}; end
      endcase
    end else begin
      c_fmt = 2'd0;
      c_sub = n_o;
      case (n_o)
        4'h0, 4'h1: c_imm = {n_a, n_b};
        4'h2: c_fl[8] = 1'b1;
        4'h3: begin c_fl[8] = 1'b1; c_fl[6] = 1'b1; end
        4'h4: c_fl[7] = 1'b1;
        4'h5: begin c_fl[7] = 1'b1; c_fl[6] = 1'b1; end
        4'hE: c_fl[3] = 1'b1;
        default: c_alu = n_o - 4'h6;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      fmt       <= 2'd0;
      sub_op    <= 4'h0;
      {rd, ra, rb} <= 12'h000;
      alu_op    <= ALU_NONE;
      imm       <= 8'h00;
      {is_load, is_store, mem_wide, is_io_rd, is_io_wr,
       is_branch, is_call, is_excr, is_illegal} <= 9'h000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        fmt    <= c_fmt;
        sub_op <= c_sub;
        {rd, ra, rb} <= {n_d, n_a, n_b};
        alu_op <= c_alu;
        imm    <= c_imm;
        {is_load, is_store, mem_wide, is_io_rd, is_io_wr,
         is_branch, is_call, is_excr, is_illegal} <= c_fl;
      end
    end
  end

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sub_op) && $stable(fmt) && $stable(imm) && $stable(alu_op)));

  p_one_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_load, is_store, is_io_rd, is_io_wr, is_branch, is_call, is_excr, is_illegal}));

  p_illegal_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    is_illegal |-> (alu_op == ALU_NONE && imm == 8'h00 && fmt == 2'd2 && !mem_wide));

  p_ldimm_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[3:1] == 3'b000) |=> (imm == $past(instr[11:4]) && fmt == 2'd0));

  p_tier2_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[7:0] == 8'hFF) |=> (fmt == 2'd2 && (is_excr || is_illegal)));

endmodule

// File: tb/nest_decoder_tb.sv
`timescale 1ns/1ps
module nest_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic out_valid, is_load, is_store, mem_wide, is_io_rd, is_io_wr;
  logic is_branch, is_call, is_excr, is_illegal;
  logic [1:0] fmt;
  logic [3:0] sub_op, rd, ra, rb, alu_op;
  logic [7:0] imm;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  nest_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .out_valid(out_valid), .fmt(fmt), .sub_op(sub_op), .rd(rd), .ra(ra), .rb(rb),
    .alu_op(alu_op), .imm(imm), .is_load(is_load), .is_store(is_store),
    .mem_wide(mem_wide), .is_io_rd(is_io_rd), .is_io_wr(is_io_wr),
    .is_branch(is_branch), .is_call(is_call), .is_excr(is_excr), .is_illegal(is_illegal)
  );

  wire [8:0] flags = {is_load, is_store, mem_wide, is_io_rd, is_io_wr,
                      is_branch, is_call, is_excr, is_illegal};
  localparam logic [8:0] F_LD = 9'h100, F_ST = 9'h080, F_W = 9'h040, F_IR = 9'h020,
                         F_IW = 9'h010, F_BR = 9'h008, F_CL = 9'h004, F_EX = 9'h002,
                         F_IL = 9'h001;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    instr = w;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic [15:0] w, input int e_fmt,
                            input int e_sub, input int e_alu, input int e_imm, input logic [8:0] e_fl);
    issue(w);
    check({tag, " valid"}, out_valid, 1);
    check({tag, " fmt"}, fmt, e_fmt);
    check({tag, " sub_op"}, sub_op, e_sub);
    check({tag, " alu_op"}, alu_op, e_alu);
    check({tag, " imm"}, imm, e_imm);
    check({tag, " flags"}, flags, e_fl);
    check({tag, " R3 fields"}, {rd, ra, rb}, w[15:4]);
  endtask

  task automatic t_reset;
    check("R1 valid", out_valid, 0);
    check("R1 fmt", fmt, 0);
    check("R1 alu", alu_op, 15);
    check("R1 imm", imm, 0);
    check("R1 flags", flags, 0);
    check("R1 sub", sub_op, 0);
  endtask

  task automatic t_primary;
    expect_all("R4 low imm", 16'h5A70, 0, 0, 15, 8'hA7, 0);
    expect_all("R4 high imm", 16'h2C31, 0, 1, 15, 8'hC3, 0);
    expect_all("R4 imm ones", 16'hEFF0, 0, 0, 15, 8'hFF, 0);
    expect_all("R5 ld8", 16'h1232, 0, 2, 15, 0, F_LD);
    expect_all("R5 ld16", 16'h1233, 0, 3, 15, 0, F_LD | F_W);
    expect_all("R5 st8", 16'h4564, 0, 4, 15, 0, F_ST);
    expect_all("R5 st16", 16'h4565, 0, 5, 15, 0, F_ST | F_W);
    for (int c = 6; c <= 13; c++)
      expect_all("R6 alu", {12'h123, 4'(c)}, 0, c, c - 6, 0, 0);
    expect_all("R6 branch", 16'h012E, 0, 14, 15, 0, F_BR);
  endtask

  task automatic t_single_src;
    expect_all("R7 pass", 16'h340F, 1, 0, 8, 0, 0);
    expect_all("R7 neg", 16'h341F, 1, 1, 9, 0, 0);
    expect_all("R7 inv", 16'h342F, 1, 2, 10, 0, 0);
    expect_all("R7 cmp", 16'h343F, 1, 3, 11, 0, 0);
    expect_all("R7 call", 16'hD24F, 1, 4, 15, 0, F_CL);
    expect_all("R7 swap", 16'h345F, 1, 5, 12, 0, 0);
  endtask

  task automatic t_io;
    expect_all("R8 in", 16'h316F, 1, 6, 15, 0, F_IR);
    expect_all("R8 out", 16'h317F, 1, 7, 15, 0, F_IW);
    expect_all("R8 in imm", 16'h3B8F, 1, 8, 15, 8'h0B, F_IR);
    expect_all("R8 out imm", 16'h359F, 1, 9, 15, 8'h05, F_IW);
  endtask

  task automatic t_imm_alu;
    expect_all("R9 add imm", 16'h27AF, 1, 10, 0, 7, 0);
    expect_all("R9 and imm", 16'h2FBF, 1, 11, 2, 15, 0);
    expect_all("R9 or imm", 16'h21CF, 1, 12, 3, 1, 0);
    expect_all("R9 shift right", 16'h29DF, 1, 13, 6, 1, 0);
    expect_all("R9 shift left", 16'h25DF, 1, 13, 5, 5, 0);
    expect_all("R9 shift right max", 16'h2FDF, 1, 13, 6, 7, 0);
    expect_all("R9 sar imm", 16'h2CEF, 1, 14, 7, 12, 0);
    expect_all("R9 sar imm ones", 16'hFFEF, 1, 14, 7, 15, 0);
  endtask

  task automatic t_single_reg;
    for (int c = 0; c <= 10; c++)
      expect_all("R10 excr", {4'h6, 4'(c), 8'hFF}, 2, c, 15, 0, F_EX);
  endtask

  task automatic t_illegal;
    for (int c = 11; c <= 15; c++)
      expect_all("R11 illegal", {4'h6, 4'(c), 8'hFF}, 2, c, 15, 0, F_IL);
    expect_all("R11 all ones", 16'hFFFF, 2, 15, 15, 0, F_IL);
  endtask

  task automatic t_hold;
    issue(16'h2C31);
    @(negedge clk);
    in_valid = 1'b0;
    instr = 16'h1233;
    @(posedge clk);
    #1;
    check("R2 valid drop", out_valid, 0);
    check("R2 hold sub", sub_op, 1);
    check("R2 hold imm", imm, 8'hC3);
    check("R2 hold flags", flags, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_primary();
        t_single_src();
        t_io();
        t_imm_alu();
        t_single_reg();
        t_illegal();
        t_hold();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule